// File: doc/BRIEF.md
# UART DMA Request Status Flags

This block produces the two request flags that a UART hands to a DMA engine: a transmit-ready flag and a receive-ready flag. It keeps an occupancy count for the transmit queue and for the receive queue. It compares the receive count against a selectable trigger level, and it runs a character time-out timer on the receive side. The serial shifters, the baud generator and the register bus sit outside the block. The block only sees one-cycle strobes: a character written into the transmit queue, a character leaving it for the shifter, a character arriving from the receiver, and a character read out by the host.

Two request styles are supported. In single-transfer style each flag simply follows whether data is present. In burst style each flag latches. The transmit flag waits until the queue is completely full and then holds until the queue is completely empty. The receive flag drops at the trigger level or on a time-out and stays down until the queue has been drained. Turning the queues off reduces each path to a one-entry holding register.

Top module: `uart_dma_ready`

## Requirements
- R1: Burst style is in force only when `dmaSel` and `fifoEn` are both 1; the three other combinations give single-transfer style.
- R2: In single-transfer style, `txReady` goes to 1 on the clock edge that takes in the first character of an empty transmit path.
- R3: In single-transfer style, `txReady` goes to 0 on the edge at which the last character leaves the transmit path.
- R4: In burst style, `txReady` rises only on the edge at which the transmit queue becomes full (16 characters); partial fill leaves it at 0.
- R5: In burst style, once `txReady` is 1 it stays 1 through partial draining, falls when the transmit path becomes empty, and stays 0 while the queue refills short of full.
- R6: In single-transfer style, `rxReady` is 1 while the receive path is empty and 0 while it holds at least one character.
- R7: In burst style, `rxReady` falls on the edge at which the receive count reaches the trigger level, stays 0 while characters are read out, and returns to 1 only when the receive path is empty.
- R8: `trigSel` encodes the receive trigger level as 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 characters.
- R9: With the receive path non-empty, 40 `baudTick` pulses (4 characters of 10 bits) with no receive push and no read raise a time-out, which in burst style drops `rxReady` on the edge of the 40th pulse.
- R10: A received character or a host read restarts the 40-pulse time-out window and clears a pending time-out.
- R11: With `fifoEn` at 0 each path holds one character; a write into an occupied transmit holding register and a push into an occupied receive holding register are ignored.
- R12: A write into a full transmit queue is ignored and does not add to the count.
- R13: Reset gives `txReady` = 0 and `rxReady` = 1 (both paths empty, no time-out); flags are registered and change only on the clock edge that samples the causing strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dmaSel | input | 1 | Selects burst request style (together with fifoEn) |
| fifoEn | input | 1 | 1 = 16-entry queues, 0 = one-entry holding registers |
| trigSel | input | 2 | Receive trigger level select |
| baudTick | input | 1 | One pulse per serial bit period |
| txWrite | input | 1 | Host writes one character to the transmit path |
| txDrain | input | 1 | One character leaves the transmit path for the shifter |
| rxPush | input | 1 | One character arrives in the receive path |
| rxPop | input | 1 | Host reads one character from the receive path |
| txReady | output | 1 | Transmit DMA request flag |
| rxReady | output | 1 | Receive DMA request flag |

## Verification
A wrong occupancy count shows up as a flag edge at the wrong character. In burst style the transmit flag rises one write early or late, and it falls one drain away from the true empty point. Filling and emptying the queue to exact counts therefore exposes an off-by-one within a single fill and drain. A stuck latch state leaves a flag unchanged across a fill or drain that should have moved it, and this is visible on the very next edge. Time-out timer errors appear as `rxReady` falling one tick early or late relative to the 40th idle baud tick.

// File: rtl/uart_dma_rdy_pkg.sv
package uart_dma_rdy_pkg;

  localparam int PATH_TX = 0;
  localparam int PATH_RX = 1;
  localparam int NUM_PATHS = 2;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BURST  = 1'b1
  } dmaMode_e;

  // accepted occupancy strobes, issued by control
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } pathStrobe_t;

  // occupancy state returned by the datapath
  typedef struct packed {
    logic txFull;
    logic txEmpty;
    logic txNextEmpty;
    logic txNextFull;
    logic rxFull;
    logic rxEmpty;
    logic rxNextEmpty;
    logic rxNextTrig;
    logic rxNextTimeout;
  } pathLevel_t;

endpackage

// File: rtl/uart_dma_rdy_datapath.sv
module uart_dma_rdy_datapath
  import uart_dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CHAR_BITS = 10,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoEn,
  input  logic [1:0]  trigSel,
  input  logic        baudTick,
  input  pathStrobe_t strobe,
  output pathLevel_t  level
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int LIMIT = CHAR_BITS * TIMEOUT_CHARS;
  localparam int TW = $clog2(LIMIT + 1);

  logic [CW-1:0] capacity;
  logic [NUM_PATHS-1:0] pushV;
  logic [NUM_PATHS-1:0] popV;
  logic [NUM_PATHS-1:0][CW-1:0] cnt;
  logic [NUM_PATHS-1:0][CW-1:0] nextCnt;
  logic [CW-1:0] trigLevel;

  assign capacity = fifoEn ? CW'(DEPTH) : CW'(1);

  assign pushV[PATH_TX] = strobe.txPush;
  assign popV[PATH_TX]  = strobe.txPop;
  assign pushV[PATH_RX] = strobe.rxPush;
  assign popV[PATH_RX]  = strobe.rxPop;

  // one occupancy counter per path
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [CW-1:0] cntQ;
    logic [CW-1:0] cntD;

    assign cntD = cntQ + CW'(pushV[p]) - CW'(popV[p]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ <= '0;
      else       cntQ <= cntD;
    end

    assign cnt[p]     = cntQ;
    assign nextCnt[p] = cntD;
  end

  // receive trigger level decode
  always_comb begin
    unique case (trigSel)
      2'b00:   trigLevel = CW'(1);
      2'b01:   trigLevel = CW'(DEPTH / 4);
      2'b10:   trigLevel = CW'(DEPTH / 2);
      default: trigLevel = CW'(DEPTH - 2);
    endcase
  end

  // character time-out timer on the receive path
  logic [TW-1:0] timerQ;
  logic [TW-1:0] timerD;
  logic timeoutQ;
  logic timeoutD;
  logic restart;
  logic counting;
  logic hit;

  assign restart  = strobe.rxPush || strobe.rxPop || (nextCnt[PATH_RX] == '0);
  assign counting = baudTick && !timeoutQ && (cnt[PATH_RX] != '0);
  assign hit      = counting && (timerQ == TW'(LIMIT - 1));

  always_comb begin
    if (restart) begin
      timerD   = '0;
      timeoutD = 1'b0;
    end else begin
      timerD   = counting ? timerQ + TW'(1) : timerQ;
      timeoutD = timeoutQ || hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ   <= '0;
      timeoutQ <= 1'b0;
    end else begin
      timerQ   <= timerD;
      timeoutQ <= timeoutD;
    end
  end

  always_comb begin
    level.txFull        = cnt[PATH_TX] >= capacity;
    level.txEmpty       = cnt[PATH_TX] == '0;
    level.txNextEmpty   = nextCnt[PATH_TX] == '0;
    level.txNextFull    = nextCnt[PATH_TX] >= capacity;
    level.rxFull        = cnt[PATH_RX] >= capacity;
    level.rxEmpty       = cnt[PATH_RX] == '0;
    level.rxNextEmpty   = nextCnt[PATH_RX] == '0;
    level.rxNextTrig    = nextCnt[PATH_RX] >= trigLevel;
    level.rxNextTimeout = timeoutD;
  end

endmodule

// File: rtl/uart_dma_rdy_control.sv
module uart_dma_rdy_control
  import uart_dma_rdy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaSel,
  input  logic        fifoEn,
  input  logic        txWrite,
  input  logic        txDrain,
  input  logic        rxPush,
  input  logic        rxPop,
  input  pathLevel_t  level,
  output pathStrobe_t strobe,
  output logic        txReady,
  output logic        rxReady
);

  dmaMode_e mode;
  logic txReadyQ, txReadyD;
  logic rxReadyQ, rxReadyD;

  assign mode = (dmaSel && fifoEn) ? DMA_BURST : DMA_SINGLE;

  // strobes into a full or empty path are dropped here
  always_comb begin
    strobe.txPush = txWrite && !level.txFull;
    strobe.txPop  = txDrain && !level.txEmpty;
    strobe.rxPush = rxPush  && !level.rxFull;
    strobe.rxPop  = rxPop   && !level.rxEmpty;
  end

  always_comb begin
    unique case (mode)
      DMA_BURST: begin
        if (level.txNextFull)       txReadyD = 1'b1;
        else if (level.txNextEmpty) txReadyD = 1'b0;
        else                        txReadyD = txReadyQ;
      end
      default: txReadyD = !level.txNextEmpty;
    endcase
  end

  always_comb begin
    unique case (mode)
      DMA_BURST: begin
        if (level.rxNextTrig || level.rxNextTimeout) rxReadyD = 1'b0;
        else if (level.rxNextEmpty)                  rxReadyD = 1'b1;
        else                                         rxReadyD = rxReadyQ;
      end
      default: rxReadyD = level.rxNextEmpty;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReadyQ <= 1'b0;
      rxReadyQ <= 1'b1;
    end else begin
      txReadyQ <= txReadyD;
      rxReadyQ <= rxReadyD;
    end
  end

  assign txReady = txReadyQ;
  assign rxReady = rxReadyQ;

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CHAR_BITS = 10,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaSel,
  input  logic       fifoEn,
  input  logic [1:0] trigSel,
  input  logic       baudTick,
  input  logic       txWrite,
  input  logic       txDrain,
  input  logic       rxPush,
  input  logic       rxPop,
  output logic       txReady,
  output logic       rxReady
);

  pathStrobe_t strobe;
  pathLevel_t  level;

  uart_dma_rdy_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .dmaSel  (dmaSel),
    .fifoEn  (fifoEn),
    .txWrite (txWrite),
    .txDrain (txDrain),
    .rxPush  (rxPush),
    .rxPop   (rxPop),
    .level   (level),
    .strobe  (strobe),
    .txReady (txReady),
    .rxReady (rxReady)
  );

  uart_dma_rdy_datapath #(
    .DEPTH         (DEPTH),
    .CHAR_BITS     (CHAR_BITS),
    .TIMEOUT_CHARS (TIMEOUT_CHARS)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEn   (fifoEn),
    .trigSel  (trigSel),
    .baudTick (baudTick),
    .strobe   (strobe),
    .level    (level)
  );

endmodule

// File: rtl/uart_dma_rdy_checker.sv
module uart_dma_rdy_checker (
  input logic       clk,
  input logic       rstN,
  input logic       dmaSel,
  input logic       fifoEn,
  input logic [1:0] trigSel,
  input logic       txWrite,
  input logic       txDrain,
  input logic       rxPush,
  input logic       rxPop,
  input logic       txReady,
  input logic       rxReady
);

  logic burst;
  assign burst = dmaSel && fifoEn;

  assert_reset_state_R13: assert property (@(posedge clk)
    !rstN |=> (!txReady && rxReady));

  assert_single_tx_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!burst && txWrite && !txDrain && !txReady) |=> txReady);

  assert_single_rx_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!burst && rxPush && !rxPop) |=> !rxReady);

  assert_burst_tx_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (burst && !txReady && !txWrite) |=> !txReady);

  assert_burst_rx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (burst && !rxReady && !rxPop) |=> !rxReady);

  assert_trigger_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    (burst && trigSel == 2'b00 && rxPush) |=> !rxReady);

endmodule

bind uart_dma_ready uart_dma_rdy_checker u_check (
  .clk     (clk),
  .rstN    (rstN),
  .dmaSel  (dmaSel),
  .fifoEn  (fifoEn),
  .trigSel (trigSel),
  .txWrite (txWrite),
  .txDrain (txDrain),
  .rxPush  (rxPush),
  .rxPop   (rxPop),
  .txReady (txReady),
  .rxReady (rxReady)
);

// File: tb/uart_dma_ready_test.sv
`timescale 1ns/1ps
module uart_dma_ready_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaSel = 1'b0;
  logic fifoEn = 1'b1;
  logic [1:0] trigSel = 2'b00;
  logic baudTick = 1'b0;
  logic txWrite = 1'b0;
  logic txDrain = 1'b0;
  logic rxPush = 1'b0;
  logic rxPop = 1'b0;
  logic txReady;
  logic rxReady;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_dma_ready uut (
    .clk(clk), .rstN(rstN), .dmaSel(dmaSel), .fifoEn(fifoEn),
    .trigSel(trigSel), .baudTick(baudTick), .txWrite(txWrite),
    .txDrain(txDrain), .rxPush(rxPush), .rxPop(rxPop),
    .txReady(txReady), .rxReady(rxReady)
  );

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic wrTx(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); txWrite = 1'b1; end
    @(negedge clk); txWrite = 1'b0;
  endtask
  task automatic drTx(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); txDrain = 1'b1; end
    @(negedge clk); txDrain = 1'b0;
  endtask
  task automatic pushRx(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rxPush = 1'b1; end
    @(negedge clk); rxPush = 1'b0;
  endtask
  task automatic popRx(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rxPop = 1'b1; end
    @(negedge clk); rxPop = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); baudTick = 1'b1; end
    @(negedge clk); baudTick = 1'b0;
  endtask
  task automatic setMode(input logic sel, input logic en, input logic [1:0] trig);
    @(negedge clk);
    dmaSel = sel; fifoEn = en; trigSel = trig;
  endtask

  task automatic t_reset();
    check("R13 reset txReady", txReady, 1'b0);
    check("R13 reset rxReady", rxReady, 1'b1);
    setMode(1'b0, 1'b1, 2'b00);
    @(negedge clk); txWrite = 1'b1;
    #2 check("R13 no change before edge", txReady, 1'b0);
    @(negedge clk); txWrite = 1'b0;
    check("R13 change on sampling edge", txReady, 1'b1);
    drTx(1);
  endtask

  task automatic t_mode_decode();
    setMode(1'b1, 1'b0, 2'b00);
    wrTx(1);
    check("R1 sel=1 en=0 is single style", txReady, 1'b1);
    drTx(1);
    setMode(1'b0, 1'b1, 2'b00);
    wrTx(1);
    check("R1 sel=0 en=1 is single style", txReady, 1'b1);
    drTx(1);
    setMode(1'b1, 1'b1, 2'b00);
    wrTx(1);
    check("R1 sel=1 en=1 is burst style", txReady, 1'b0);
    drTx(1);
    check("R1 burst drained", txReady, 1'b0);
  endtask

  task automatic t_single_tx();
    setMode(1'b0, 1'b1, 2'b00);
    wrTx(1);
    check("R2 first write sets", txReady, 1'b1);
    wrTx(2);
    check("R2 stays set with 3", txReady, 1'b1);
    drTx(2);
    check("R3 set while 1 left", txReady, 1'b1);
    drTx(1);
    check("R3 clears when empty", txReady, 1'b0);
  endtask

  task automatic t_burst_tx();
    setMode(1'b1, 1'b1, 2'b00);
    wrTx(15);
    check("R4 not set at 15", txReady, 1'b0);
    wrTx(1);
    check("R4 set at full", txReady, 1'b1);
    wrTx(1);
    check("R12 write at full keeps set", txReady, 1'b1);
    drTx(15);
    check("R5 holds while 1 left", txReady, 1'b1);
    drTx(1);
    check("R12 extra write dropped, empty after 16", txReady, 1'b0);
    wrTx(8);
    check("R5 stays clear while refilling", txReady, 1'b0);
    drTx(8);
    check("R5 clear after drain", txReady, 1'b0);
  endtask

  task automatic t_single_rx();
    setMode(1'b0, 1'b1, 2'b11);
    pushRx(1);
    check("R6 clears on first char", rxReady, 1'b0);
    pushRx(1);
    popRx(1);
    check("R6 clear while 1 left", rxReady, 1'b0);
    popRx(1);
    check("R6 set when empty", rxReady, 1'b1);
  endtask

  task automatic t_burst_rx();
    setMode(1'b1, 1'b1, 2'b01);
    pushRx(3);
    check("R7 set below trigger", rxReady, 1'b1);
    pushRx(1);
    check("R7 clears at trigger 4", rxReady, 1'b0);
    popRx(3);
    check("R7 stays clear while draining", rxReady, 1'b0);
    popRx(1);
    check("R7 set again when empty", rxReady, 1'b1);
  endtask

  task automatic t_trigger_levels();
    setMode(1'b1, 1'b1, 2'b00);
    pushRx(1);
    check("R8 level 1 reached", rxReady, 1'b0);
    popRx(1);
    setMode(1'b1, 1'b1, 2'b10);
    pushRx(7);
    check("R8 level 8 not at 7", rxReady, 1'b1);
    pushRx(1);
    check("R8 level 8 reached", rxReady, 1'b0);
    popRx(8);
    setMode(1'b1, 1'b1, 2'b11);
    pushRx(13);
    check("R8 level 14 not at 13", rxReady, 1'b1);
    pushRx(1);
    check("R8 level 14 reached", rxReady, 1'b0);
    popRx(14);
    check("R8 drained", rxReady, 1'b1);
  endtask

  task automatic t_timeout();
    setMode(1'b1, 1'b1, 2'b11);
    pushRx(2);
    ticks(39);
    check("R9 no time-out at 39", rxReady, 1'b1);
    pushRx(1);
    ticks(39);
    check("R10 push restarts window", rxReady, 1'b1);
    popRx(1);
    ticks(39);
    check("R10 read restarts window", rxReady, 1'b1);
    ticks(1);
    check("R9 time-out at 40th tick", rxReady, 1'b0);
    popRx(1);
    check("R9 stays clear until empty", rxReady, 1'b0);
    popRx(1);
    check("R9 set again when empty", rxReady, 1'b1);
  endtask

  task automatic t_no_fifo();
    setMode(1'b1, 1'b0, 2'b00);
    wrTx(2);
    check("R11 tx holding set", txReady, 1'b1);
    drTx(1);
    check("R11 second tx write dropped", txReady, 1'b0);
    pushRx(2);
    check("R11 rx holding full", rxReady, 1'b0);
    popRx(1);
    check("R11 second rx push dropped", rxReady, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_decode();
    t_single_tx();
    t_burst_tx();
    t_single_rx();
    t_burst_rx();
    t_trigger_levels();
    t_timeout();
    t_no_fifo();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule